// File: doc/BRIEF.md
# Descriptor-Ring SPI Master

This block is an SPI master whose transfers are described by two small rings of descriptors rather than by a byte-at-a-time register interface. Software places outgoing bytes in a local transmit byte store and describes each buffer with a transmit descriptor: ready flag, last flag, byte count and start pointer. It also prepares receive descriptors, each with an empty flag, a capacity and a pointer into a local receive byte store. A one-cycle start pulse then sends the whole chain.

For every character the engine drives eight clock pulses and shifts a byte out on MOSI while it samples a byte in on MISO. Received bytes go into the buffer of the current receive descriptor. When a transmit buffer is finished, its ready flag is cleared. Transmission then continues into the next ring entry without a gap, or it stops if the last flag was set. A stop also closes the active receive descriptor, even when that buffer is only partly filled. Every closed descriptor raises a pending interrupt, which can be masked. An underrun (chain broken by a descriptor that is not ready) and an overrun (no empty receive descriptor) are reported as sticky flags.

All descriptors and bytes are reached through a single host port with a table select. Descriptor words use this layout: bit 15 is the ready flag (transmit) or the empty flag (receive); bit 14 is the last flag (transmit) or the error flag (receive); bits 12:8 hold the length; bits 3:0 hold the pointer.

Top module: `spi_desc_master`

## Requirements
- R1: A transfer begins only on the clock edge where `start` is high and the current transmit descriptor has bit 15 set. Otherwise `start` is ignored: `busy` stays low and no clock pulse appears.
- R2: `spi_sclk` rests low whenever `busy` is low. Each half period lasts `clk_div`+1 system clocks, so rising edges are 2×(`clk_div`+1) clocks apart, and each character has 8 pulses.
- R3: Data is MSB first. MOSI changes only while `spi_sclk` is low, and MISO is sampled on each rising edge.
- R4: A transmit descriptor sends exactly its length in bytes (bits 12:8), taken from the transmit byte store from its pointer upward.
- R5: When a transmit buffer is done, bit 15 of its descriptor is cleared, its other fields are kept, and an interrupt becomes pending.
- R6: If bit 14 of the finished transmit descriptor is clear and the next descriptor is ready, sending continues without a start pulse. The rising-edge spacing stays uniform across the buffer boundary.
- R7: If bit 14 of the finished transmit descriptor is set, the engine stops and `busy` falls.
- R8: Each received byte is written at pointer plus count in the buffer of the current receive descriptor with bit 15 set. Once the count reaches the capacity, bit 15 is cleared, bits 12:8 take the received count, and the ring advances.
- R9: When transmission stops, the active receive descriptor is closed with the bytes it has so far, so its length may be below its capacity.
- R10: If the chain reaches a transmit descriptor that is not ready, the engine stops, raises `underrun`, and closes the active receive descriptor with bit 14 set.
- R11: A character that arrives while the current receive descriptor has bit 15 clear is dropped, and the receive store is left untouched. `overrun` is raised.
- R12: Both rings step from index 3 back to index 0.
- R13: `irq` is the pending interrupt gated by `irq_en`. `irq_ack` clears the pending interrupt, `underrun` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Table: 0 tx descriptors, 1 rx descriptors, 2 tx bytes, 3 rx bytes |
| host_addr | input | 4 | Entry index within the selected table |
| host_wdata | input | 16 | Write data (bytes use bits 7:0) |
| host_rdata | output | 16 | Combinational read of the selected entry |
| start | input | 1 | Start command pulse |
| clk_div | input | 8 | Half-period divider value |
| irq_en | input | 1 | Interrupt mask enable |
| irq_ack | input | 1 | Clears pending interrupt and error flags |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| underrun | output | 1 | Sticky chain-break flag |
| overrun | output | 1 | Sticky dropped-character flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a buffer boundary inside a running chain. At that boundary the engine must either continue with no gap, or detect that the next descriptor is not ready and close a partly filled receive buffer with an error. The bench reaches it by preparing multi-descriptor chains with unequal transmit lengths and receive capacities before a single start. It timestamps every clock rising edge so that any idle gap at the boundary shows up as an irregular interval. An underrun is reached by leaving the following descriptor unset in a chain whose first descriptor has its last flag clear.

// File: rtl/spi_ring_pkg.sv
`timescale 1ns/1ps
package spi_ring_pkg;
  typedef enum logic [1:0] {
    SEL_TXD = 2'd0,
    SEL_RXD = 2'd1,
    SEL_TXB = 2'd2,
    SEL_RXB = 2'd3
  } host_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned F_OWN  = 15;  // ready (tx) / empty (rx)
  localparam int unsigned F_AUX  = 14;  // last (tx) / error (rx)
  localparam int unsigned F_LEN  = 8;   // length field lsb
  localparam int unsigned F_PTR  = 0;   // pointer field lsb
endpackage

// File: rtl/spi_clkgen.sv
`timescale 1ns/1ps
module spi_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             wrap;

  always_comb begin
    wrap = run && (cnt_q == div);
    rise = wrap && !sclk_q;
    fall = wrap && sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_byte,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic              char_done,
  output logic [CHAR_W-1:0] rx_byte
);
  localparam int unsigned BW = $clog2(CHAR_W);

  logic [CHAR_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic              last_bit;

  always_comb begin
    last_bit  = (bit_q == BW'(CHAR_W-1));
    char_done = fall && last_bit;
    tx_d  = tx_q;
    bit_d = bit_q;
    rx_d  = rx_q;
    if (load) begin
      tx_d  = load_byte;
      bit_d = '0;
    end else if (fall) begin
      tx_d  = {tx_q[CHAR_W-2:0], 1'b0};
      bit_d = last_bit ? '0 : bit_q + 1'b1;
    end
    if (rise) rx_d = {rx_q[CHAR_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      bit_q <= bit_d;
    end
  end

  assign mosi    = tx_q[CHAR_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_store.sv
`timescale 1ns/1ps
module spi_store
  import spi_ring_pkg::*;
#(
  parameter int unsigned NDESC     = 4,
  parameter int unsigned BUF_BYTES = 16,
  localparam int unsigned IW = $clog2(NDESC),
  localparam int unsigned PW = $clog2(BUF_BYTES),
  localparam int unsigned AW = (PW > IW) ? PW : IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              txd_we,
  input  logic [IW-1:0]     txd_widx,
  input  logic [WORD_W-1:0] txd_wdata,
  input  logic              rxd_we,
  input  logic [IW-1:0]     rxd_widx,
  input  logic [WORD_W-1:0] rxd_wdata,
  input  logic              rxb_we,
  input  logic [PW-1:0]     rxb_waddr,
  input  logic [7:0]        rxb_wdata,
  input  logic [IW-1:0]     txd_ridx,
  output logic [WORD_W-1:0] txd_rdata,
  input  logic [IW-1:0]     nxt_ridx,
  output logic              nxt_rdy,
  output logic [PW-1:0]     nxt_ptr,
  input  logic [IW-1:0]     rxd_ridx,
  output logic [WORD_W-1:0] rxd_rdata,
  input  logic [PW-1:0]     txb_raddr,
  output logic [7:0]        txb_rdata
);
  logic [WORD_W-1:0] txd_q [NDESC];
  logic [WORD_W-1:0] rxd_q [NDESC];
  logic [7:0]        txb_q [BUF_BYTES];
  logic [7:0]        rxb_q [BUF_BYTES];

  for (genvar g = 0; g < NDESC; g++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        txd_q[g] <= '0;
        rxd_q[g] <= '0;
      end else begin
        if (txd_we && txd_widx == IW'(g))
          txd_q[g] <= txd_wdata;
        else if (host_we && host_sel == SEL_TXD && host_addr[IW-1:0] == IW'(g))
          txd_q[g] <= host_wdata;
        if (rxd_we && rxd_widx == IW'(g))
          rxd_q[g] <= rxd_wdata;
        else if (host_we && host_sel == SEL_RXD && host_addr[IW-1:0] == IW'(g))
          rxd_q[g] <= host_wdata;
      end
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        txb_q[g] <= '0;
        rxb_q[g] <= '0;
      end else begin
        if (host_we && host_sel == SEL_TXB && host_addr[PW-1:0] == PW'(g))
          txb_q[g] <= host_wdata[7:0];
        if (rxb_we && rxb_waddr == PW'(g))
          rxb_q[g] <= rxb_wdata;
        else if (host_we && host_sel == SEL_RXB && host_addr[PW-1:0] == PW'(g))
          rxb_q[g] <= host_wdata[7:0];
      end
    end
  end

  always_comb begin
    case (host_sel)
      SEL_TXD: host_rdata = txd_q[host_addr[IW-1:0]];
      SEL_RXD: host_rdata = rxd_q[host_addr[IW-1:0]];
      SEL_TXB: host_rdata = {8'h00, txb_q[host_addr[PW-1:0]]};
      default: host_rdata = {8'h00, rxb_q[host_addr[PW-1:0]]};
    endcase
  end

  assign txd_rdata = txd_q[txd_ridx];
  assign nxt_rdy   = txd_q[nxt_ridx][F_OWN];
  assign nxt_ptr   = txd_q[nxt_ridx][F_PTR +: PW];
  assign rxd_rdata = rxd_q[rxd_ridx];
  assign txb_rdata = txb_q[txb_raddr];
endmodule

// File: rtl/spi_desc_master.sv
`timescale 1ns/1ps
module spi_desc_master
  import spi_ring_pkg::*;
#(
  parameter int unsigned NDESC     = 4,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned DIV_W     = 8,
  localparam int unsigned IW    = $clog2(NDESC),
  localparam int unsigned PW    = $clog2(BUF_BYTES),
  localparam int unsigned LEN_W = PW + 1,
  localparam int unsigned AW    = (PW > IW) ? PW : IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              start,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              underrun,
  output logic              overrun,
  output logic              irq
);
  function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] i);
    return (i == IW'(NDESC-1)) ? '0 : i + 1'b1;
  endfunction

  eng_state_e        st_q, st_d;
  logic [IW-1:0]     txi_q, txi_d, rxi_q, rxi_d;
  logic [LEN_W-1:0]  bcnt_q, bcnt_d, rcnt_q, rcnt_d, rcnt_new;
  logic              pend_q, pend_d, unr_q, unr_d, ovr_q, ovr_d;

  logic              txd_we, rxd_we, rxb_we;
  logic [WORD_W-1:0] txd_wdata, rxd_wdata, cur_tx, cur_rx;
  logic [PW-1:0]     rxb_waddr, txb_raddr, nxt_ptr;
  logic [7:0]        txb_rdata, rx_byte;
  logic              nxt_rdy;
  logic              load, sc_rise, sc_fall, char_done;
  logic              stop, unr_now, ev;

  spi_store #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .txd_we(txd_we), .txd_widx(txi_q), .txd_wdata(txd_wdata),
    .rxd_we(rxd_we), .rxd_widx(rxi_q), .rxd_wdata(rxd_wdata),
    .rxb_we(rxb_we), .rxb_waddr(rxb_waddr), .rxb_wdata(rx_byte),
    .txd_ridx(txi_q), .txd_rdata(cur_tx),
    .nxt_ridx(ring_next(txi_q)), .nxt_rdy(nxt_rdy), .nxt_ptr(nxt_ptr),
    .rxd_ridx(rxi_q), .rxd_rdata(cur_rx),
    .txb_raddr(txb_raddr), .txb_rdata(txb_rdata)
  );

  spi_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_RUN), .div(clk_div),
    .sclk(spi_sclk), .rise(sc_rise), .fall(sc_fall)
  );

  spi_shifter #(.CHAR_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(txb_rdata),
    .rise(sc_rise), .fall(sc_fall), .miso(spi_miso),
    .mosi(spi_mosi), .char_done(char_done), .rx_byte(rx_byte)
  );

  // next-state: descriptor walk
  always_comb begin
    st_d   = st_q;
    txi_d  = txi_q;
    rxi_d  = rxi_q;
    bcnt_d = bcnt_q;
    rcnt_d = rcnt_q;
    load   = 1'b0;
    stop   = 1'b0;
    unr_now = 1'b0;
    ev     = 1'b0;
    txb_raddr = cur_tx[F_PTR +: PW];
    txd_we    = 1'b0;
    txd_wdata = cur_tx;
    txd_wdata[F_OWN] = 1'b0;
    rxd_we    = 1'b0;
    rxb_we    = 1'b0;
    rcnt_new  = rcnt_q + 1'b1;
    rxb_waddr = cur_rx[F_PTR +: PW] + rcnt_q[PW-1:0];
    rxd_wdata = cur_rx;

    if (st_q == ST_IDLE) begin
      if (start && cur_tx[F_OWN]) begin
        st_d   = ST_RUN;
        load   = 1'b1;
        bcnt_d = LEN_W'(1);
      end
    end else if (char_done) begin
      if (bcnt_q < cur_tx[F_LEN +: LEN_W]) begin
        txb_raddr = cur_tx[F_PTR +: PW] + bcnt_q[PW-1:0];
        load      = 1'b1;
        bcnt_d    = bcnt_q + 1'b1;
      end else begin
        txd_we = 1'b1;
        ev     = 1'b1;
        txi_d  = ring_next(txi_q);
        if (cur_tx[F_AUX]) begin
          stop = 1'b1;
        end else if (nxt_rdy) begin
          txb_raddr = nxt_ptr;
          load      = 1'b1;
          bcnt_d    = LEN_W'(1);
        end else begin
          stop    = 1'b1;
          unr_now = 1'b1;
        end
      end
      if (stop) st_d = ST_IDLE;

      if (cur_rx[F_OWN]) begin
        rxb_we = 1'b1;
        if (rcnt_new >= cur_rx[F_LEN +: LEN_W] || stop) begin
          rxd_we = 1'b1;
          rxd_wdata[F_OWN] = 1'b0;
          rxd_wdata[F_AUX] = unr_now;
          rxd_wdata[F_LEN +: LEN_W] = rcnt_new;
          rxi_d  = ring_next(rxi_q);
          rcnt_d = '0;
          ev     = 1'b1;
        end else begin
          rcnt_d = rcnt_new;
        end
      end
    end

    pend_d = ev      ? 1'b1 : (irq_ack ? 1'b0 : pend_q);
    unr_d  = unr_now ? 1'b1 : (irq_ack ? 1'b0 : unr_q);
    ovr_d  = (st_q == ST_RUN && char_done && !cur_rx[F_OWN]) ? 1'b1 :
             (irq_ack ? 1'b0 : ovr_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      txi_q  <= '0;
      rxi_q  <= '0;
      bcnt_q <= '0;
      rcnt_q <= '0;
      pend_q <= 1'b0;
      unr_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      txi_q  <= txi_d;
      rxi_q  <= rxi_d;
      bcnt_q <= bcnt_d;
      rcnt_q <= rcnt_d;
      pend_q <= pend_d;
      unr_q  <= unr_d;
      ovr_q  <= ovr_d;
    end
  end

  assign busy     = (st_q == ST_RUN);
  assign underrun = unr_q;
  assign overrun  = ovr_q;
  assign irq      = pend_q & irq_en;
endmodule

// File: rtl/spi_desc_master_chk.sv
`timescale 1ns/1ps
module spi_desc_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic underrun,
  input logic irq,
  input logic irq_en
);
  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  p_sclk_moves_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk != $past(spi_sclk)) |-> $past(busy));

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  p_underrun_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !busy);

  p_irq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $past(irq_en)) |-> $past(busy));
endmodule

bind spi_desc_master spi_desc_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .underrun(underrun),
  .irq(irq), .irq_en(irq_en)
);

// File: tb/tb_spi_desc_master.sv
`timescale 1ns/1ps
module tb_spi_desc_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [3:0]  host_addr = 4'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        start = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic        irq_en = 1'b1;
  logic        irq_ack = 1'b0;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic        busy, underrun, overrun, irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  spi_desc_master dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .start(start), .clk_div(clk_div), .irq_en(irq_en), .irq_ack(irq_ack),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .busy(busy), .underrun(underrun), .overrun(overrun), .irq(irq)
  );

  // slave model: mode 0, MSB first, byte k = spat(k)
  function automatic logic [7:0] spat(input int i);
    return 8'(i * 37 + 11) ^ 8'h5A;
  endfunction

  int schar = 0;
  int sbit = 0;
  logic [7:0] scur;
  assign scur = spat(schar);
  assign spi_miso = scur[3'(7 - sbit)];

  always @(negedge spi_sclk) begin
    if (rst_n) begin
      if (sbit == 7) begin sbit = 0; schar = schar + 1; end
      else sbit = sbit + 1;
    end
  end

  // monitor: captured MOSI bytes and rising-edge times
  int nrise = 0;
  int nlog = 0;
  int mbit = 0;
  logic [7:0] msr = 8'd0;
  logic [7:0] mlog [64];
  time rise_t [512];

  always @(posedge spi_sclk) begin
    if (rst_n) begin
      msr = {msr[6:0], spi_mosi};
      rise_t[nrise % 512] = $time;
      nrise = nrise + 1;
      mbit = mbit + 1;
      if (mbit == 8) begin
        mlog[nlog % 64] = msr;
        nlog = nlog + 1;
        mbit = 0;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; host_we = 1'b0; irq_ack = 1'b0; irq_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hwr(input int sel, input int addr, input int data);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'(sel); host_addr = 4'(addr); host_wdata = 16'(data);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input int sel, input int addr, output int data);
    @(negedge clk);
    host_sel = 2'(sel); host_addr = 4'(addr);
    #1 data = int'(host_rdata);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk({tag, " completes"}, longint'(busy), 0);
  endtask

  task automatic chk_rises(input string tag, input int from, input int cnt, input int div);
    int errs = 0;
    for (int j = from + 1; j < from + cnt; j++) begin
      if (rise_t[j % 512] - rise_t[(j - 1) % 512] != time'(20 * (div + 1))) errs++;
    end
    chk({tag, " rise spacing"}, errs, 0);
    chk({tag, " rise count"}, nrise - from, cnt);
  endtask

  // vectors: {div[23:16], len[15:8], tx seed[7:0]}
  localparam logic [23:0] VEC [4] = '{24'h00_01_30, 24'h01_03_41, 24'h03_02_52, 24'h00_05_63};

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, l0, r0, s0;

    // reset state
    do_reset();
    chk("R2 reset sclk low", spi_sclk, 0);
    chk("R1 reset not busy", busy, 0);
    chk("R13 reset irq", irq, 0);
    chk("R10 reset underrun", underrun, 0);
    chk("R11 reset overrun", overrun, 0);
    hrd(0, 0, d); chk("R5 reset tx desc", d, 0);

    // R1: start with tx descriptor not ready is ignored
    l0 = nlog; r0 = nrise;
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R1 not-ready start busy", busy, 0);
    chk("R1 not-ready start no clock", nrise - r0, 0);

    // table of single-buffer transfers
    foreach (VEC[v]) begin
      int div, len, seed;
      div = int'(VEC[v][23:16]); len = int'(VEC[v][15:8]); seed = int'(VEC[v][7:0]);
      do_reset();
      clk_div = 8'(div);
      for (int k = 0; k < len; k++) hwr(2, 2 + k, (seed + 17 * k) & 255);
      hwr(0, 0, 16'hC000 | (len << 8) | 2);
      hwr(1, 0, 16'h8000 | (len << 8) | 5);
      l0 = nlog; r0 = nrise; s0 = schar;
      pulse_start();
      @(negedge clk);
      wait_idle("R7 single");
      for (int k = 0; k < len; k++)
        chk("R4 R3 mosi byte", mlog[(l0 + k) % 64], (seed + 17 * k) & 255);
      for (int k = 0; k < len; k++) begin
        hrd(3, 5 + k, d); chk("R8 R3 rx byte", d, spat(s0 + k));
      end
      hrd(0, 0, d); chk("R5 tx ready cleared", d, 16'h4000 | (len << 8) | 2);
      hrd(1, 0, d); chk("R8 rx closed full", d, (len << 8) | 5);
      chk("R13 irq after done", irq, 1);
      chk_rises("R2 single", r0, len * 8, div);
      pulse_ack();
      chk("R13 ack clears irq", irq, 0);
    end

    // R6/R9: two-buffer chain, rx capacities 4+4, 5 bytes sent
    do_reset();
    clk_div = 8'd1;
    irq_en = 1'b0;
    hwr(2, 0, 8'h11); hwr(2, 1, 8'h22);
    hwr(2, 8, 8'h33); hwr(2, 9, 8'h44); hwr(2, 10, 8'h55);
    hwr(0, 0, 16'h8000 | (2 << 8) | 0);
    hwr(0, 1, 16'hC000 | (3 << 8) | 8);
    hwr(1, 0, 16'h8000 | (4 << 8) | 0);
    hwr(1, 1, 16'h8000 | (4 << 8) | 8);
    l0 = nlog; r0 = nrise; s0 = schar;
    pulse_start();
    @(negedge clk);
    wait_idle("R6 chain");
    chk_rises("R6 chain gapless", r0, 40, 1);
    chk("R6 chain byte 1", mlog[(l0 + 1) % 64], 8'h22);
    chk("R6 chain byte 2", mlog[(l0 + 2) % 64], 8'h33);
    chk("R6 chain byte 4", mlog[(l0 + 4) % 64], 8'h55);
    hrd(0, 0, d); chk("R5 chain tx0", d, (2 << 8) | 0);
    hrd(0, 1, d); chk("R5 chain tx1", d, 16'h4000 | (3 << 8) | 8);
    hrd(1, 0, d); chk("R8 chain rx0 full", d, (4 << 8) | 0);
    hrd(1, 1, d); chk("R9 chain rx1 early close", d, (1 << 8) | 8);
    hrd(3, 3, d); chk("R8 chain rx0 last byte", d, spat(s0 + 3));
    hrd(3, 8, d); chk("R9 chain rx1 byte", d, spat(s0 + 4));
    chk("R13 masked irq", irq, 0);
    @(negedge clk); irq_en = 1'b1;
    #1 chk("R13 unmask irq", irq, 1);
    pulse_ack();

    // R10: underrun
    do_reset();
    hwr(2, 0, 8'hA7);
    hwr(0, 0, 16'h8000 | (1 << 8) | 0);
    hwr(1, 0, 16'h8000 | (4 << 8) | 0);
    s0 = schar;
    pulse_start();
    @(negedge clk);
    wait_idle("R10 underrun");
    chk("R10 underrun flag", underrun, 1);
    chk("R10 no overrun", overrun, 0);
    hrd(1, 0, d); chk("R10 rx closed with error", d, 16'h4000 | (1 << 8) | 0);
    hrd(3, 0, d); chk("R10 rx byte kept", d, spat(s0));
    pulse_ack();
    chk("R13 ack clears underrun", underrun, 0);

    // R11: overrun, no empty rx descriptor
    do_reset();
    hwr(3, 0, 8'hEE);
    hwr(2, 0, 8'h5C); hwr(2, 1, 8'hC5);
    hwr(0, 0, 16'hC000 | (2 << 8) | 0);
    l0 = nlog;
    pulse_start();
    @(negedge clk);
    wait_idle("R11 overrun");
    chk("R11 overrun flag", overrun, 1);
    chk("R11 bytes still sent", nlog - l0, 2);
    hrd(3, 0, d); chk("R11 rx store untouched", d, 8'hEE);
    hrd(1, 0, d); chk("R11 rx desc untouched", d, 0);
    pulse_ack();
    chk("R13 ack clears overrun", overrun, 0);

    // R12: ring wrap after four single transfers
    do_reset();
    for (int i = 0; i < 4; i++) begin
      hwr(2, i, 8'h80 + i);
      hwr(0, i, 16'hC000 | (1 << 8) | i);
      hwr(1, i, 16'h8000 | (1 << 8) | i);
      pulse_start();
      @(negedge clk);
      wait_idle("R12 ring step");
    end
    hwr(2, 7, 8'h3C);
    hwr(0, 0, 16'hC000 | (1 << 8) | 7);
    hwr(1, 0, 16'h8000 | (1 << 8) | 9);
    l0 = nlog; s0 = schar;
    pulse_start();
    @(negedge clk);
    wait_idle("R12 wrap");
    chk("R12 wrapped tx byte", mlog[l0 % 64], 8'h3C);
    hrd(1, 0, d); chk("R12 wrapped rx desc", d, (1 << 8) | 9);
    hrd(3, 9, d); chk("R12 wrapped rx byte", d, spat(s0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule